// File: doc/BRIEF.md
# Hardware Breakpoint Address Comparator

This block checks one memory or I/O access against four breakpoint slots and reports which slots it hits. Each slot holds an address. A shared 32-bit control word gives each slot an enable pair, a type code and a length code. The length code turns the slot address into a small aligned window of 1, 2, 4 or 8 bytes. A slot hits when that window overlaps any byte of the access.

The access is described by:
- a start address,
- a byte count from 1 to 8,
- a kind: read, write or I/O.

A read hits only read/write-type slots. A write also hits write-only slots. An I/O access hits only I/O-type slots, and only while the debug-extensions enable is high.

Results are registered. The match vector and the hit pulse appear one cycle after an access strobe. In a cycle without a strobe both outputs are zero. The match vector is meant to be ORed into the low four bits of a debug status register, and the hit pulse is meant to raise an asynchronous event.

Top module: `bp_addr_cmp`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `match_vec` is 0 and `hit` is 0.
- R2: If `acc_valid` was low in the previous cycle, `match_vec` and `hit` are 0, even when the inputs would otherwise match.
- R3: The result of an access with `acc_valid` high appears in the cycle after the strobe and lasts for exactly that one cycle.
- R4: The length code of slot n selects the window size: 00 gives 1 byte, 01 gives 2 bytes, 11 gives 4 bytes, 10 gives 8 bytes. The window starts at the slot address with its low bits cleared to that size.
- R5: A slot matches when the access bytes `acc_addr` through `acc_addr+acc_size-1` overlap the window; both ends are inclusive.
- R6: `acc_kind` is coded read=00, write=01, I/O=10. The slot type code 11 accepts reads and writes. Type 01 accepts only writes. Type 10 accepts only I/O. Kind 11 matches nothing.
- R7: An I/O access produces no match while `dbg_ext_en` is low.
- R8: Slot n takes part only when control bit 2n or bit 2n+1 is set. With all of control bits [7:0] clear, nothing matches.
- R9: Slot n takes its type code from control bits [17+4n:16+4n] and its length code from bits [19+4n:18+4n].
- R10: Every matching slot sets its own bit of `match_vec` (slot n on bit n). `hit` is high exactly when `match_vec` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe; the inputs below are sampled when it is high |
| acc_addr | input | 32 | Access start address |
| acc_size | input | 4 | Access length in bytes, 1 to 8 |
| acc_kind | input | 2 | Access kind: 00 read, 01 write, 10 I/O |
| slot_addr | input | 128 | Slot addresses; slot n occupies bits [32n+31:32n] |
| bp_ctrl | input | 32 | Breakpoint control word (enable, type and length fields) |
| dbg_ext_en | input | 1 | Debug-extensions enable; gates I/O comparisons |
| match_vec | output | 4 | Registered per-slot match flags |
| hit | output | 1 | Registered pulse, high when any slot matched |

## Verification
The only state in this block is the output register, so any internal fault shows at the ports one cycle after the strobe that exposed it. If the window start or end is computed wrongly, a probe one byte outside or exactly on the window edge reports the wrong bit. If a field is decoded from the wrong position or with the wrong type test, a slot set up for another kind or length raises a bit it should leave clear. A register that keeps its value past its cycle shows as a nonzero output in the idle cycle that follows each access.

// File: rtl/bpcmp_pkg.sv
// Shared definitions for the breakpoint comparator.
// Assumes access kinds arrive as a 2-bit code and slot length codes as 2 bits.
package bpcmp_pkg;

    typedef enum logic [1:0] {
        KIND_READ  = 2'b00,
        KIND_WRITE = 2'b01,
        KIND_IO    = 2'b10,
        KIND_RSVD  = 2'b11
    } access_kind_e;

    localparam logic [1:0] TYPE_WRONLY = 2'b01;
    localparam logic [1:0] TYPE_IO     = 2'b10;
    localparam logic [1:0] TYPE_RDWR   = 2'b11;

    // Low-bit mask for a length code: 00->1 byte, 01->2, 11->4, 10->8.
    function automatic logic [2:0] len_to_mask(input logic [1:0] code);
        case (code)
            2'b00:   len_to_mask = 3'd0;
            2'b01:   len_to_mask = 3'd1;
            2'b11:   len_to_mask = 3'd3;
            default: len_to_mask = 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/bp_slot_window.sv
// Turns one slot address and its length code into an inclusive aligned window.
// Assumes ADDR_W >= 3. The window end never wraps, because the start is
// aligned to the window size.
module bp_slot_window
    import bpcmp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [1:0]        len_code,
    output logic [ADDR_W-1:0] win_lo,
    output logic [ADDR_W-1:0] win_hi
);

    logic [ADDR_W-1:0] low_mask;

    // Align the slot address down and add the size mask to get the last byte.
    always_comb begin
        low_mask = ADDR_W'(len_to_mask(len_code));
        win_lo   = base_addr & ~low_mask;
        win_hi   = win_lo | low_mask;
    end

endmodule

// File: rtl/bp_slot_check.sv
// Decides whether one slot matches the current access: the spans overlap,
// the slot is enabled and its type code accepts the access kind.
// Assumes the access span end is given one bit wider so that it cannot wrap.
module bp_slot_check
    import bpcmp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] span_lo,
    input  logic [ADDR_W:0]   span_hi,
    input  logic [ADDR_W-1:0] win_lo,
    input  logic [ADDR_W-1:0] win_hi,
    input  logic [1:0]        type_code,
    input  access_kind_e      kind,
    input  logic              slot_en,
    output logic              slot_hit
);

    logic overlap;
    logic kind_ok;

    // Inclusive overlap of [span_lo, span_hi] with [win_lo, win_hi].
    always_comb overlap = (span_lo <= win_hi) && (span_hi >= {1'b0, win_lo});

    // Type acceptance per access kind.
    always_comb begin
        case (kind)
            KIND_READ:  kind_ok = (type_code == TYPE_RDWR);
            KIND_WRITE: kind_ok = (type_code == TYPE_RDWR) || (type_code == TYPE_WRONLY);
            KIND_IO:    kind_ok = (type_code == TYPE_IO);
            default:    kind_ok = 1'b0;
        endcase
    end

    // Combine the three conditions.
    always_comb slot_hit = overlap && kind_ok && slot_en;

endmodule

// File: rtl/bp_addr_cmp.sv
// Compares one access against NUM_SLOTS breakpoint slots and registers the
// per-slot result together with an any-match pulse.
// Control layout: enable pair at bits 2n/2n+1, type at 16+4n, length at 18+4n.
// Assumes NUM_SLOTS <= 8 (so the enable bits stay below bit 16) and an
// access size between 1 and 8.
module bp_addr_cmp
    import bpcmp_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4,
    parameter int SIZE_W    = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        acc_valid,
    input  logic [ADDR_W-1:0]           acc_addr,
    input  logic [SIZE_W-1:0]           acc_size,
    input  logic [1:0]                  acc_kind,
    input  logic [NUM_SLOTS*ADDR_W-1:0] slot_addr,
    input  logic [16+4*NUM_SLOTS-1:0]   bp_ctrl,
    input  logic                        dbg_ext_en,
    output logic [NUM_SLOTS-1:0]        match_vec,
    output logic                        hit
);

    localparam int SPAN_W  = ADDR_W + 1;
    localparam int EN_BITS = 2 * NUM_SLOTS;
    localparam int TYPE_LO = 16;

    access_kind_e          kind;
    logic [SPAN_W-1:0]     span_hi;
    logic                  any_enable;
    logic                  compare_on;
    logic [NUM_SLOTS-1:0]  raw_hit;

    // Decode the access kind and the inclusive last byte of the access.
    always_comb begin
        kind    = access_kind_e'(acc_kind);
        span_hi = {1'b0, acc_addr} + SPAN_W'(acc_size) - SPAN_W'(1);
    end

    // Global gate: a strobe, at least one enable bit, and I/O only with extensions on.
    always_comb begin
        any_enable = |bp_ctrl[EN_BITS-1:0];
        compare_on = acc_valid && any_enable && !((kind == KIND_IO) && !dbg_ext_en);
    end

    generate
        if (EN_BITS < TYPE_LO) begin : g_spare
            logic ctrl_unused;
            // Control bits between the enables and the slot fields carry no function.
            always_comb ctrl_unused = ^bp_ctrl[TYPE_LO-1:EN_BITS];
        end

        for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
            logic [ADDR_W-1:0] win_lo;
            logic [ADDR_W-1:0] win_hi;

            bp_slot_window #(.ADDR_W(ADDR_W)) u_win (
                .base_addr (slot_addr[n*ADDR_W +: ADDR_W]),
                .len_code  (bp_ctrl[TYPE_LO + 4*n + 2 +: 2]),
                .win_lo    (win_lo),
                .win_hi    (win_hi)
            );

            bp_slot_check #(.ADDR_W(ADDR_W)) u_chk (
                .span_lo   (acc_addr),
                .span_hi   (span_hi),
                .win_lo    (win_lo),
                .win_hi    (win_hi),
                .type_code (bp_ctrl[TYPE_LO + 4*n +: 2]),
                .kind      (kind),
                .slot_en   (|bp_ctrl[2*n +: 2]),
                .slot_hit  (raw_hit[n])
            );
        end
    endgenerate

    // Output register: result for a strobed access, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec <= '0;
            hit       <= 1'b0;
        end else if (compare_on) begin
            match_vec <= raw_hit;
            hit       <= |raw_hit;
        end else begin
            match_vec <= '0;
            hit       <= 1'b0;
        end
    end

endmodule

// File: rtl/bp_addr_cmp_chk.sv
// Temporal checks on the comparator ports; attached by bind below.
// Assumes the same parameters as the instance it is bound to.
module bp_addr_cmp_chk #(
    parameter int ADDR_W    = 32,
    parameter int NUM_SLOTS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      acc_valid,
    input logic [1:0]                acc_kind,
    input logic [16+4*NUM_SLOTS-1:0] bp_ctrl,
    input logic                      dbg_ext_en,
    input logic [NUM_SLOTS-1:0]      match_vec,
    input logic                      hit
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> (match_vec == '0) && !hit); // R2

    AST_HIT_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        hit == (match_vec != '0)); // R10

    AST_IO_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && acc_kind == 2'b10 && !dbg_ext_en) |-> (match_vec == '0)); // R7

    AST_RSVD_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && acc_kind == 2'b11) |-> (match_vec == '0)); // R6

    generate
        for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot_chk
            AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
                match_vec[n] |-> $past(bp_ctrl[2*n] || bp_ctrl[2*n+1])); // R8

            AST_READ_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
                (match_vec[n] && $past(acc_kind == 2'b00))
                    |-> $past(bp_ctrl[16+4*n +: 2] == 2'b11)); // R6
        end
    endgenerate

endmodule

bind bp_addr_cmp bp_addr_cmp_chk #(.ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)) u_bp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_kind   (acc_kind),
    .bp_ctrl    (bp_ctrl),
    .dbg_ext_en (dbg_ext_en),
    .match_vec  (match_vec),
    .hit        (hit)
);

// File: tb/sim_bp_addr_cmp.sv
// Scoreboard bench: the driver queues expected results, the monitor compares them.
module sim_bp_addr_cmp;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [3:0]  acc_size = 4'd1;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] s0 = '0, s1 = '0, s2 = '0, s3 = '0;
    logic [31:0] bp_ctrl = '0;
    logic        dbg_ext_en = 1'b0;
    logic [3:0]  match_vec;
    logic        hit;

    int tests = 0;
    int fails = 0;
    logic [3:0] exp_v[$];
    string      exp_tag[$];

    always #5 clk = ~clk;

    bp_addr_cmp u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .acc_size   (acc_size),
        .acc_kind   (acc_kind),
        .slot_addr  ({s3, s2, s1, s0}),
        .bp_ctrl    (bp_ctrl),
        .dbg_ext_en (dbg_ext_en),
        .match_vec  (match_vec),
        .hit        (hit)
    );

    // Control word: enables in [7:0], slot n type at 16+4n, length at 18+4n.
    function automatic logic [31:0] mk_ctrl(input logic [7:0] en,
        input logic [1:0] t0, input logic [1:0] l0, input logic [1:0] t1, input logic [1:0] l1,
        input logic [1:0] t2, input logic [1:0] l2, input logic [1:0] t3, input logic [1:0] l3);
        mk_ctrl = {l3, t3, l2, t2, l1, t1, l0, t0, 8'h00, en};
    endfunction

    task automatic check(input logic [3:0] ev, input string tag);
        tests++;
        if (match_vec !== ev || hit !== (ev != 4'd0)) begin
            fails++;
            $display("FAIL %s: match_vec=%b hit=%b expected match_vec=%b hit=%b",
                     tag, match_vec, hit, ev, (ev != 4'd0));
        end
    endtask

    // Driver: one strobed access, then one idle cycle with the inputs held.
    task automatic access(input logic [31:0] a, input logic [3:0] sz, input logic [1:0] k,
                          input logic [3:0] ev, input string tag);
        @(negedge clk);
        acc_addr = a; acc_size = sz; acc_kind = k; acc_valid = 1'b1;
        exp_v.push_back(ev); exp_tag.push_back(tag);
        @(negedge clk);
        acc_valid = 1'b0;
        exp_v.push_back(4'd0); exp_tag.push_back({tag, " idle R2 R3"});
    endtask

    // Monitor: compares each result just after the edge that registers it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_v.size() > 0) check(exp_v.pop_front(), exp_tag.pop_front());
        end
    end

    // Watchdog.
    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        s0 = 32'h0000_1000; s1 = 32'h0000_2003; s2 = 32'h0000_3005; s3 = 32'h0000_4001;
        bp_ctrl = mk_ctrl(8'hFF, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b01);
        acc_valid = 1'b1; acc_addr = 32'h1000;
        repeat (3) @(posedge clk);
        #1 check(4'd0, "R1 during reset");
        @(negedge clk);
        acc_valid = 1'b0; rst_n = 1'b1;
        @(posedge clk);
        #1 check(4'd0, "R1 after reset");

        // R4 R5: slot0 is 1 byte at 0x1000
        access(32'h1000, 4'd1, 2'b00, 4'b0001, "R5 exact byte");
        access(32'h0FFF, 4'd1, 2'b00, 4'b0000, "R5 byte below window");
        access(32'h0FFF, 4'd2, 2'b00, 4'b0001, "R5 span reaches window");
        access(32'h1001, 4'd1, 2'b00, 4'b0000, "R5 byte above window");
        // R4 R9: slot1 4 bytes 0x2000..0x2003, slot2 8 bytes 0x3000..0x3007, slot3 2 bytes 0x4000..0x4001
        access(32'h2000, 4'd1, 2'b00, 4'b0010, "R4 4-byte aligned start");
        access(32'h2004, 4'd1, 2'b00, 4'b0000, "R4 4-byte past end");
        access(32'h3007, 4'd1, 2'b00, 4'b0100, "R4 8-byte last byte");
        access(32'h3008, 4'd1, 2'b00, 4'b0000, "R4 8-byte past end");
        access(32'h4000, 4'd1, 2'b00, 4'b1000, "R4 2-byte start R9");
        access(32'h4002, 4'd1, 2'b00, 4'b0000, "R4 2-byte past end");
        access(32'h2FFC, 4'd8, 2'b00, 4'b0100, "R5 8-byte span into slot2");

        // R8: slot1 enabled only through bit 3, others off
        bp_ctrl = mk_ctrl(8'h08, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b01);
        access(32'h2001, 4'd1, 2'b00, 4'b0010, "R8 high enable bit");
        access(32'h1000, 4'd1, 2'b00, 4'b0000, "R8 disabled slot0");
        bp_ctrl = mk_ctrl(8'h00, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 2'b11, 2'b01);
        access(32'h2001, 4'd1, 2'b00, 4'b0000, "R8 all enables clear");

        // R6: slot0 write-only
        bp_ctrl = mk_ctrl(8'h01, 2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        access(32'h1000, 4'd1, 2'b00, 4'b0000, "R6 read vs write-only");
        access(32'h1000, 4'd1, 2'b01, 4'b0001, "R6 write vs write-only");
        bp_ctrl = mk_ctrl(8'h01, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        access(32'h1000, 4'd1, 2'b01, 4'b0001, "R6 write vs read/write");
        access(32'h1000, 4'd1, 2'b10, 4'b0000, "R6 io vs read/write");
        access(32'h1000, 4'd1, 2'b11, 4'b0000, "R6 reserved kind");
        // R6 R7: slot0 I/O type
        bp_ctrl = mk_ctrl(8'h01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00);
        dbg_ext_en = 1'b1;
        access(32'h1000, 4'd1, 2'b10, 4'b0001, "R6 io with extensions");
        access(32'h1000, 4'd1, 2'b00, 4'b0000, "R6 read vs io type");
        dbg_ext_en = 1'b0;
        access(32'h1000, 4'd1, 2'b10, 4'b0000, "R7 io without extensions");

        // R10: all slots share an 8-byte window
        s0 = 32'h5000; s1 = 32'h5001; s2 = 32'h5006; s3 = 32'h5007;
        bp_ctrl = mk_ctrl(8'hFF, 2'b11, 2'b10, 2'b11, 2'b10, 2'b11, 2'b10, 2'b11, 2'b10);
        access(32'h5004, 4'd4, 2'b00, 4'b1111, "R10 all slots");
        bp_ctrl = mk_ctrl(8'hFF, 2'b11, 2'b10, 2'b01, 2'b10, 2'b11, 2'b10, 2'b10, 2'b10);
        access(32'h5004, 4'd4, 2'b00, 4'b0101, "R10 mixed types R9");

        repeat (3) @(posedge clk);
        #2;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule